// File: doc/BRIEF.md
# I2C Controller FIFO Threshold Event Logic

This block holds the transmit and receive byte FIFOs of an I2C controller and decides when software should be asked to move data. Software fills the transmit FIFO and empties the receive FIFO through a byte-wide data port. The serial bit engine takes transmit bytes and delivers received bytes through single-cycle strobes. Each programmable threshold is written as the threshold value minus one. From the FIFO levels, the two thresholds and a remaining-byte counter, the block derives four events every cycle. Two are data-ready events: the transmit side needs a threshold's worth of data, or the receive side holds a threshold's worth of data. The other two are draining events. They fire when the rest of the transfer can never reach the threshold, so software moves exactly the bytes that are left.

The four events are latched into a sticky status vector that software clears by writing ones. A single interrupt line is the OR of the status bits that are also set in an enable mask. A small transfer sequencer has four states. XS_IDLE goes to XS_TX_RUN or to XS_RX_RUN on a start with a nonzero length. XS_TX_RUN returns to XS_IDLE when the last byte leaves the transmit FIFO. XS_RX_RUN goes to XS_RX_TAIL when the last byte arrives. XS_RX_TAIL returns to XS_IDLE once the receive FIFO is empty. FIFO depth is 8 shifted left by a depth code, and that code is reported on an output.

Top module: `i2c_fifo_evt`

## Requirements
- R1: After reset both FIFO levels are 0, the status vector is 0, irq is 0 and the sequencer is idle.
- R2: Thresholds are given as value minus one: tx_thr_m1 = TX threshold - 1 and rx_thr_m1 = RX threshold - 1, so each threshold lies in 1..64.
- R3: The transmit FIFO delivers bytes on eng_tx_byte in the order they were written. A cpu_wr while tx_level equals the depth is ignored, and the level and contents stay unchanged.
- R4: The receive FIFO presents bytes on cpu_rdata in arrival order. A cpu_rd while rx_level is 0 is ignored, and the level stays 0.
- R5: xfer_start in idle with a nonzero xfer_len loads the remaining count with xfer_len and selects receive when xfer_rx=1, otherwise transmit. A start with length 0, or a start while a transfer is active, is ignored.
- R6: Status bit 0 (transmit request) is set while transmitting when tx_level < TX threshold and need >= TX threshold. Here need = remaining - tx_level when remaining > tx_level, and 0 otherwise.
- R7: Status bit 1 (transmit drain) is set while transmitting when tx_level < TX threshold and 0 < need < TX threshold. Bits 0 and 1 are never requested together.
- R8: Status bit 2 (receive available) is set during a receive transfer, including its tail, when rx_level >= RX threshold.
- R9: Status bit 3 (receive drain) is set once the remaining count is 0 in a receive transfer and 0 < rx_level < RX threshold.
- R10: Status bits are sticky. Writing 1 to a bit of sts_w1c clears it, unless its event is active in that same cycle, in which case the bit stays set.
- R11: irq is 1 exactly when some status bit and its irq_en bit are both 1.
- R12: A tx_flush or rx_flush pulse empties the corresponding FIFO, and its level reads 0 afterwards.
- R13: depth_code reports DEPTH_CODE, and each FIFO holds 8 << DEPTH_CODE bytes (16 by default).
- R14: The remaining count drops by one for every byte the engine actually moves. A transmit transfer ends when it reaches 0. A receive transfer ends when it is 0 and the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_thr_m1 | input | 6 | Transmit threshold minus one |
| rx_thr_m1 | input | 6 | Receive threshold minus one |
| tx_flush | input | 1 | Empty the transmit FIFO |
| rx_flush | input | 1 | Empty the receive FIFO |
| xfer_start | input | 1 | Start a transfer |
| xfer_rx | input | 1 | 1 = receive transfer, 0 = transmit |
| xfer_len | input | CNT_W | Transfer byte count |
| cpu_wr | input | 1 | Software writes a byte into the transmit FIFO |
| cpu_wdata | input | 8 | Byte written by software |
| cpu_rd | input | 1 | Software pops the receive FIFO |
| cpu_rdata | output | 8 | Head of the receive FIFO |
| eng_tx_take | input | 1 | Bit engine takes a transmit byte |
| eng_tx_byte | output | 8 | Head of the transmit FIFO |
| eng_rx_put | input | 1 | Bit engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_level | output | DEPTH_CODE+4 | Transmit FIFO fill level |
| rx_level | output | DEPTH_CODE+4 | Receive FIFO fill level |
| depth_code | output | 4 | FIFO depth code |
| sts_w1c | input | 4 | Write-one-to-clear strobe per status bit |
| irq_en | input | 4 | Interrupt enable mask |
| sts | output | 4 | Status: 0 tx request, 1 tx drain, 2 rx available, 3 rx drain |
| irq | output | 1 | Masked interrupt |

## Verification
Directed transmit sequences move the level and the remaining count across the threshold in both directions. This separates a request from a drain and shows the two never overlap. Receive sequences fill to the threshold and then end the transfer below it, which separates the available event from the draining one. Random rounds draw thresholds, lengths and preload or delivery counts, then compare the status against event functions built from the requirements. Corner cases cover a full transmit FIFO, an empty receive pop, a zero-length start, a start while busy, flushes, a clear that loses to an active event, and the interrupt mask.

// File: rtl/i2cfe_pkg.sv
`timescale 1ns/1ps
package i2cfe_pkg;

    typedef enum logic [1:0] {
        XS_IDLE    = 2'd0,
        XS_TX_RUN  = 2'd1,
        XS_RX_RUN  = 2'd2,
        XS_RX_TAIL = 2'd3
    } xfer_state_e;

    // status bit positions
    localparam int EV_TX_REQ   = 0;
    localparam int EV_TX_DRAIN = 1;
    localparam int EV_RX_AVAIL = 2;
    localparam int EV_RX_DRAIN = 3;
    localparam int EV_NUM      = 4;

    localparam int THR_W = 6;

endpackage

// File: rtl/i2cfe_fifo.sv
`timescale 1ns/1ps
module i2cfe_fifo #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [AW:0]   level
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   cnt;
    logic          push_ok, pop_ok;

    assign push_ok = push && (cnt != (AW+1)'(DEPTH));
    assign pop_ok  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = mem[rptr];
    assign level = cnt;
endmodule

// File: rtl/i2cfe_ctrl.sv
`timescale 1ns/1ps
module i2cfe_ctrl
    import i2cfe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_rx,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             tx_move,
    input  logic             rx_move,
    input  logic             rx_empty,
    output logic [CNT_W-1:0] remaining,
    output logic             tx_active,
    output logic             rx_active,
    output logic             rx_tail
);
    xfer_state_e state_q, state_n;
    logic        accept;
    logic        last_byte;

    assign accept    = (state_q == XS_IDLE) && xfer_start && (xfer_len != '0);
    assign last_byte = (remaining == CNT_W'(1));

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            XS_IDLE:    if (accept) state_n = xfer_rx ? XS_RX_RUN : XS_TX_RUN;
            XS_TX_RUN:  if (tx_move && last_byte) state_n = XS_IDLE;
            XS_RX_RUN:  if (rx_move && last_byte) state_n = XS_RX_TAIL;
            XS_RX_TAIL: if (rx_empty) state_n = XS_IDLE;
            default:    state_n = XS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_n;
    end

    // remaining byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (accept) begin
            remaining <= xfer_len;
        end else if ((tx_move || rx_move) && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_active = 1'b0;
        rx_active = 1'b0;
        rx_tail   = 1'b0;
        unique case (state_q)
            XS_IDLE:    ;
            XS_TX_RUN:  tx_active = 1'b1;
            XS_RX_RUN:  rx_active = 1'b1;
            XS_RX_TAIL: begin
                rx_active = 1'b1;
                rx_tail   = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/i2cfe_evt.sv
`timescale 1ns/1ps
module i2cfe_evt
    import i2cfe_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic              rx_tail,
    input  logic [CNT_W-1:0]  remaining,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [THR_W-1:0]  tx_thr_m1,
    input  logic [THR_W-1:0]  rx_thr_m1,
    input  logic [EV_NUM-1:0] sts_w1c,
    input  logic [EV_NUM-1:0] irq_en,
    output logic [EV_NUM-1:0] cond,
    output logic [EV_NUM-1:0] sts,
    output logic              irq
);
    logic [CNT_W-1:0] tx_lvl, rx_lvl, tx_thr, rx_thr, tx_need;
    logic             tx_low;

    always_comb begin
        tx_lvl  = CNT_W'(tx_level);
        rx_lvl  = CNT_W'(rx_level);
        tx_thr  = CNT_W'(tx_thr_m1) + CNT_W'(1);
        rx_thr  = CNT_W'(rx_thr_m1) + CNT_W'(1);
        tx_need = (remaining > tx_lvl) ? (remaining - tx_lvl) : '0;
        tx_low  = tx_lvl < tx_thr;

        cond              = '0;
        cond[EV_TX_REQ]   = tx_active && tx_low && (tx_need >= tx_thr);
        cond[EV_TX_DRAIN] = tx_active && tx_low && (tx_need != '0) && (tx_need < tx_thr);
        cond[EV_RX_AVAIL] = rx_active && (rx_lvl >= rx_thr);
        cond[EV_RX_DRAIN] = rx_tail && (rx_lvl != '0) && (rx_lvl < rx_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~sts_w1c) | cond;
    end

    assign irq = |(sts & irq_en);
endmodule

// File: rtl/i2c_fifo_evt.sv
`timescale 1ns/1ps
module i2c_fifo_evt
    import i2cfe_pkg::*;
#(
    parameter int DEPTH_CODE = 1,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [5:0]            tx_thr_m1,
    input  logic [5:0]            rx_thr_m1,
    input  logic                  tx_flush,
    input  logic                  rx_flush,
    input  logic                  xfer_start,
    input  logic                  xfer_rx,
    input  logic [CNT_W-1:0]      xfer_len,
    input  logic                  cpu_wr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_rd,
    output logic [7:0]            cpu_rdata,
    input  logic                  eng_tx_take,
    output logic [7:0]            eng_tx_byte,
    input  logic                  eng_rx_put,
    input  logic [7:0]            eng_rx_byte,
    output logic [DEPTH_CODE+3:0] tx_level,
    output logic [DEPTH_CODE+3:0] rx_level,
    output logic [3:0]            depth_code,
    input  logic [3:0]            sts_w1c,
    input  logic [3:0]            irq_en,
    output logic [3:0]            sts,
    output logic                  irq
);
    localparam int AW    = DEPTH_CODE + 3;
    localparam int LVL_W = AW + 1;
    localparam int DEPTH = 8 << DEPTH_CODE;

    logic             tx_act, rx_act, rx_tl;
    logic             tx_move, rx_move;
    logic [CNT_W-1:0] rem_q;
    logic [EV_NUM-1:0] ev_cond;

    assign tx_move = eng_tx_take && tx_act && (tx_level != '0);
    assign rx_move = eng_rx_put && rx_act && !rx_tl && (rx_level != LVL_W'(DEPTH));

    i2cfe_fifo #(.AW(AW), .DW(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (cpu_wr),
        .wdata (cpu_wdata),
        .pop   (tx_move),
        .rdata (eng_tx_byte),
        .level (tx_level)
    );

    i2cfe_fifo #(.AW(AW), .DW(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_move),
        .wdata (eng_rx_byte),
        .pop   (cpu_rd),
        .rdata (cpu_rdata),
        .level (rx_level)
    );

    i2cfe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_rx    (xfer_rx),
        .xfer_len   (xfer_len),
        .tx_move    (tx_move),
        .rx_move    (rx_move),
        .rx_empty   (rx_level == '0),
        .remaining  (rem_q),
        .tx_active  (tx_act),
        .rx_active  (rx_act),
        .rx_tail    (rx_tl)
    );

    i2cfe_evt #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_act),
        .rx_active (rx_act),
        .rx_tail   (rx_tl),
        .remaining (rem_q),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_thr_m1 (tx_thr_m1),
        .rx_thr_m1 (rx_thr_m1),
        .sts_w1c   (sts_w1c),
        .irq_en    (irq_en),
        .cond      (ev_cond),
        .sts       (sts),
        .irq       (irq)
    );

    assign depth_code = 4'(DEPTH_CODE);
endmodule

// File: rtl/i2cfe_chk.sv
`timescale 1ns/1ps
module i2cfe_chk #(
    parameter int LVL_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [3:0]       cond,
    input logic [3:0]       sts,
    input logic [3:0]       sts_w1c,
    input logic             xfer_start,
    input logic [CNT_W-1:0] xfer_len,
    input logic             tx_active,
    input logic             rx_active,
    input logic             cpu_rd,
    input logic             eng_rx_put,
    input logic [CNT_W-1:0] remaining
);
    localparam int DEPTH = 1 << (LVL_W - 1);

    // R3
    tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));

    // R7
    tx_evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond[0] && cond[1]));

    // R4
    rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0 && cpu_rd && !eng_rx_put) |=> (rx_level == '0));

    // R5
    zero_len_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !rx_active && xfer_start && xfer_len == '0)
        |=> (!tx_active && !rx_active));

    // R14
    rem_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> (remaining <= $past(remaining)));

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & sts_w1c & ~cond) != 4'b0)
        |=> ((sts & $past(sts_w1c & ~cond)) == 4'b0));
endmodule

bind i2c_fifo_evt i2cfe_chk #(.LVL_W(DEPTH_CODE + 4), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .cond       (ev_cond),
    .sts        (sts),
    .sts_w1c    (sts_w1c),
    .xfer_start (xfer_start),
    .xfer_len   (xfer_len),
    .tx_active  (tx_act),
    .rx_active  (rx_act),
    .cpu_rd     (cpu_rd),
    .eng_rx_put (eng_rx_put),
    .remaining  (rem_q)
);

// File: tb/i2c_fifo_evt_tb.sv
`timescale 1ns/1ps
module i2c_fifo_evt_tb;
    localparam int DEPTH = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       tx_thr_m1 = '0, rx_thr_m1 = '0;
    logic             tx_flush = 0, rx_flush = 0;
    logic             xfer_start = 0, xfer_rx = 0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic             cpu_wr = 0, cpu_rd = 0;
    logic [7:0]       cpu_wdata = '0, cpu_rdata;
    logic             eng_tx_take = 0, eng_rx_put = 0;
    logic [7:0]       eng_tx_byte, eng_rx_byte = '0;
    logic [4:0]       tx_level, rx_level;
    logic [3:0]       depth_code;
    logic [3:0]       sts_w1c = '0, irq_en = '0, sts;
    logic             irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int b_rem = 0;
    bit b_busy = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    i2c_fifo_evt #(.DEPTH_CODE(1), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .xfer_start(xfer_start),
        .xfer_rx(xfer_rx), .xfer_len(xfer_len), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte),
        .eng_rx_put(eng_rx_put), .eng_rx_byte(eng_rx_byte),
        .tx_level(tx_level), .rx_level(rx_level), .depth_code(depth_code),
        .sts_w1c(sts_w1c), .irq_en(irq_en), .sts(sts), .irq(irq)
    );

    task automatic chk(input string tag, input int got, input int exp_v);
        n_chk++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp_v);
        end
    endtask

    function automatic int exp_tx(input int lvl, input int rem, input int thr);
        int need;
        need = (rem > lvl) ? rem - lvl : 0;
        if (rem == 0 || lvl >= thr) return 0;
        if (need >= thr) return 1;
        if (need > 0) return 2;
        return 0;
    endfunction

    function automatic int exp_rx(input int lvl, input int rem, input int thr);
        int r;
        r = 0;
        if (lvl >= thr) r += 1;
        if (rem == 0 && lvl > 0 && lvl < thr) r += 2;
        return r;
    endfunction

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_sts();
        @(negedge clk); sts_w1c = 4'hF;
        @(negedge clk); sts_w1c = 4'h0;
        settle();
    endtask

    task automatic start(input bit rx, input int len);
        @(negedge clk); xfer_start = 1; xfer_rx = rx; xfer_len = CNT_W'(len);
        @(negedge clk); xfer_start = 0;
        if (!b_busy && len != 0) begin
            b_busy = 1;
            b_rem  = len;
        end
    endtask

    task automatic cpu_push(input logic [7:0] v);
        @(negedge clk); cpu_wr = 1; cpu_wdata = v;
        @(negedge clk); cpu_wr = 0;
        if (txq.size() < DEPTH) txq.push_back(v);
    endtask

    task automatic take_tx();
        @(negedge clk);
        chk("R3 transmit order", int'(eng_tx_byte), int'(txq[0]));
        eng_tx_take = 1;
        @(negedge clk); eng_tx_take = 0;
        void'(txq.pop_front());
        b_rem--;
        if (b_rem == 0) b_busy = 0;
    endtask

    task automatic rx_put(input logic [7:0] v);
        @(negedge clk); eng_rx_put = 1; eng_rx_byte = v;
        @(negedge clk); eng_rx_put = 0;
        rxq.push_back(v);
        b_rem--;
    endtask

    task automatic cpu_pop();
        @(negedge clk);
        chk("R4 receive order", int'(cpu_rdata), int'(rxq[0]));
        cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
        void'(rxq.pop_front());
        if (b_rem == 0 && rxq.size() == 0) b_busy = 0;
    endtask

    task automatic flush_both();
        @(negedge clk); tx_flush = 1; rx_flush = 1;
        @(negedge clk); tx_flush = 0; rx_flush = 0;
        txq.delete(); rxq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 sts", int'(sts), 0);
        chk("R1 irq", int'(irq), 0);
        // R13 depth code
        chk("R13 depth_code", int'(depth_code), 1);

        // R2 thresholds: TX 4, RX 3
        tx_thr_m1 = 6'd3;
        rx_thr_m1 = 6'd2;

        // transmit directed
        start(0, 10);
        settle();
        chk("R6 request at start", int'(sts[1:0]), 1);
        clear_sts();
        chk("R10 clear loses to active event", int'(sts[0]), 1);
        for (int i = 0; i < 4; i++) cpu_push(8'hA0 + 8'(i));
        clear_sts();
        chk("R10 clear after event drops", int'(sts[1:0]), 0);
        take_tx();
        settle();
        chk("R6 request below threshold", int'(sts[1:0]), 1);
        for (int i = 0; i < 3; i++) cpu_push(8'hB0 + 8'(i));
        clear_sts();
        for (int i = 0; i < 3; i++) take_tx();
        settle();
        chk("R7 drain when residue short", int'(sts[1:0]), 2);
        for (int i = 0; i < 3; i++) cpu_push(8'hC0 + 8'(i));
        while (b_rem > 0) take_tx();
        settle();
        chk("R14 transmit finished level", int'(tx_level), 0);
        clear_sts();
        chk("R14 no events when idle", int'(sts), 0);

        // zero-length start ignored
        start(0, 0);
        cpu_push(8'h11);
        @(negedge clk); eng_tx_take = 1;
        @(negedge clk); eng_tx_take = 0;
        settle();
        chk("R5 zero-length start ignored", int'(tx_level), 1);
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        txq.delete();
        chk("R12 tx flush", int'(tx_level), 0);

        // full transmit FIFO
        for (int i = 0; i < DEPTH + 2; i++) cpu_push(8'(i + 1));
        chk("R3 full level", int'(tx_level), DEPTH);
        chk("R3 head kept", int'(eng_tx_byte), 1);
        flush_both();

        // receive directed, threshold 3
        start(1, 5);
        rx_put(8'h51); rx_put(8'h52);
        settle();
        chk("R8 below threshold", int'(sts[3:2]), 0);
        rx_put(8'h53);
        settle();
        chk("R8 available at threshold", int'(sts[2]), 1);
        irq_en = 4'b0000;
        #1 chk("R11 masked irq", int'(irq), 0);
        irq_en = 4'b0100;
        #1 chk("R11 enabled irq", int'(irq), 1);
        irq_en = 4'b0000;
        for (int i = 0; i < 3; i++) cpu_pop();
        clear_sts();
        chk("R10 receive clear", int'(sts[3:2]), 0);
        start(0, 9);
        rx_put(8'h54); rx_put(8'h55);
        settle();
        chk("R9 receive drain", int'(sts[3:2]), 2);
        chk("R5 busy start ignored", int'(sts[1:0]), 0);
        cpu_pop(); cpu_pop();
        @(negedge clk); cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
        settle();
        chk("R4 pop on empty", int'(rx_level), 0);
        clear_sts();

        start(1, 3);
        rx_put(8'h61); rx_put(8'h62); rx_put(8'h63);
        @(negedge clk); rx_flush = 1;
        @(negedge clk); rx_flush = 0;
        rxq.delete(); b_busy = 0;
        chk("R12 rx flush", int'(rx_level), 0);
        settle();
        clear_sts();

        // random transmit rounds
        for (int it = 0; it < 30; it++) begin
            int thr, len, pre, k, lim;
            thr = 1 + int'($urandom % 8);
            tx_thr_m1 = 6'(thr - 1);
            len = 1 + int'($urandom % 20);
            lim = (len < DEPTH) ? len : DEPTH;
            pre = int'($urandom % (lim + 1));
            flush_both();
            for (int i = 0; i < pre; i++) cpu_push(8'($urandom));
            start(0, len);
            clear_sts();
            chk("R6 R7 random start", int'(sts[1:0]), exp_tx(pre, len, thr));
            k = int'($urandom % (pre + 1));
            if (k == len) k = len - 1;
            for (int i = 0; i < k; i++) take_tx();
            clear_sts();
            chk("R6 R7 random after takes", int'(sts[1:0]), exp_tx(txq.size(), b_rem, thr));
            while (b_rem > 0) begin
                if (txq.size() == 0) cpu_push(8'($urandom));
                take_tx();
            end
            settle();
        end

        // random receive rounds
        for (int it = 0; it < 30; it++) begin
            int thr, len, k, lim;
            thr = 1 + int'($urandom % 8);
            rx_thr_m1 = 6'(thr - 1);
            len = 1 + int'($urandom % 20);
            lim = (len < DEPTH) ? len : DEPTH;
            k = int'($urandom % (lim + 1));
            start(1, len);
            for (int i = 0; i < k; i++) rx_put(8'($urandom));
            clear_sts();
            chk("R8 R9 random receive", int'(sts[3:2]), exp_rx(k, b_rem, thr));
            while (b_rem > 0 || rxq.size() > 0) begin
                if (b_rem > 0 && rxq.size() < DEPTH) rx_put(8'($urandom));
                else cpu_pop();
            end
            settle();
            b_busy = 0;
            clear_sts();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule